// File: doc/BRIEF.md
# Double-Step Xorshift-Rotate Random Number Unit

This unit serves one generator command of a simple processor. It takes a 32-bit state word from a general register and splits it into two 16-bit halves. In a single cycle it applies two chained xorshift-rotate steps to that word. It returns the advanced state on a combinational output, so the pipeline can write it back to the same register. In the same cycle it scrambles the state after each step into a 16-bit word. To do this it adds the two halves and replaces the least significant bit of the sum with the parity of the whole 17-bit sum, carry included. The two words together form a 32-bit random result, which the unit keeps apart from the state.

The result is captured when the command completes and is held for the operand path. The next instruction that issues receives it in place of its own source operand. From capture until that instruction issues, the unit raises an interrupt shield, so no interrupt can separate the producer from its consumer. Seeding means loading any non-zero value into the register before the command. An all-zero state stays all zero and yields a zero result, and no error is signalled.

Top module: `prng_dstep_unit`

## Requirements
- R1: One step on a state whose low half is a and high half is b computes t = a XOR b. The new high half is t rotated left by 7. The new low half is (a rotated left by 14) XOR (t shifted left by 2) XOR t.
- R2: `state_out` is the state after two such steps applied to `state_in`. It is combinational and valid in the same cycle as `state_in`.
- R3: Each scrambled word is formed from s = low half + high half of a post-step state, taken as a 17-bit sum with carry. Word bits [15:1] equal s[15:1], and word bit 0 equals the XOR of all 17 bits of s.
- R4: The result holds the word from the first step in bits [15:0] and the word from the second step in bits [31:16].
- R5: On a clock edge with `cmd_valid` high, the result is captured. While the forward flag is set, `src_operand_out` carries that captured result. Otherwise it equals `src_operand_in`.
- R6: The forward flag is set by a clock edge with `cmd_valid` high and cleared by a clock edge with `issue_strobe` high and `cmd_valid` low. If both are high on the same edge, the flag stays set and the newly captured result replaces the old one.
- R7: `irq_hold` is high exactly while the forward flag is set, and it can only rise after a command.
- R8: An all-zero `state_in` gives an all-zero `state_out`, and a command on it forwards an all-zero result.
- R9: A synchronous active-low reset clears the forward flag, so after reset `irq_hold` is low and the operand passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Generator command issued this cycle |
| state_in | input | 32 | State word read from the source register |
| state_out | output | 32 | State advanced by two steps, for write-back |
| issue_strobe | input | 1 | Any other instruction issues this cycle |
| src_operand_in | input | 32 | Source operand of the issuing instruction |
| src_operand_out | output | 32 | Source operand after substitution |
| irq_hold | output | 1 | Interrupts must not be taken while high |

## Verification
A new generator command and the issue of the instruction that consumes the previous result can fall on the same clock edge. The bench sets this up by asserting `cmd_valid` and `issue_strobe` together while a result is still waiting. In that cycle it expects the old result on `src_operand_out`. After the edge it expects `irq_hold` to stay high and the new result to appear. Apart from this case, long chains of commands from several seeds are compared word by word against a model that steps one iteration at a time and rebuilds both sums and parities.

// File: rtl/prng_dstep_pkg.sv
// Package: default geometry and step constants shared by the generator unit.
// Assumes: the state is two equal halves; rotation amounts are below the half width.
package prng_dstep_pkg;
    localparam int XO_HALF_W = 16;  // width of one state half
    localparam int XO_ROT_A  = 14;  // rotate applied to the low half
    localparam int XO_SHL_B  = 2;   // left shift applied to the mixed word
    localparam int XO_ROT_C  = 7;   // rotate forming the new high half
    localparam int XO_STEPS  = 2;   // steps chained per command
endpackage

// File: rtl/xo_step.sv
// Module: one combinational xorshift-rotate step on a two-half state.
// Assumes: low half in the lower bits; ROT_A, SHL_B and ROT_C all lie in 1..HALF_W-1.
module xo_step #(
    parameter int HALF_W = prng_dstep_pkg::XO_HALF_W,
    parameter int ROT_A  = prng_dstep_pkg::XO_ROT_A,
    parameter int SHL_B  = prng_dstep_pkg::XO_SHL_B,
    parameter int ROT_C  = prng_dstep_pkg::XO_ROT_C
) (
    input  logic [2*HALF_W-1:0] state_i,
    output logic [2*HALF_W-1:0] state_o
);
    logic [HALF_W-1:0] lo, hi, mix, lo_rot, new_lo, new_hi;

    // Split, mix and recombine the halves.
    always_comb begin
        lo     = state_i[HALF_W-1:0];
        hi     = state_i[2*HALF_W-1:HALF_W];
        mix    = lo ^ hi;
        lo_rot = (lo << ROT_A) | (lo >> (HALF_W - ROT_A));
        new_lo = lo_rot ^ (mix << SHL_B) ^ mix;
        new_hi = (mix << ROT_C) | (mix >> (HALF_W - ROT_C));
        state_o = {new_hi, new_lo};
    end
endmodule

// File: rtl/xo_scramble.sv
// Module: turns one post-step state into a parity-adjusted output word.
// Assumes: the full-width sum plus carry feeds the parity; the carry itself is dropped.
module xo_scramble #(
    parameter int HALF_W = prng_dstep_pkg::XO_HALF_W
) (
    input  logic [2*HALF_W-1:0] state_i,
    output logic [HALF_W-1:0]   word_o
);
    logic [HALF_W:0] sum;

    // Add halves with carry, then put the total parity in the low bit.
    always_comb begin
        sum    = {1'b0, state_i[HALF_W-1:0]} + {1'b0, state_i[2*HALF_W-1:HALF_W]};
        word_o = {sum[HALF_W-1:1], ^sum};
    end
endmodule

// File: rtl/xo_forward.sv
// Module: holds the generator result for the next issued instruction and shields interrupts.
// Assumes: cmd_i and issue_i are single-cycle strobes from the issue stage; a command wins a tie.
module xo_forward #(
    parameter int RES_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_i,
    input  logic             issue_i,
    input  logic [RES_W-1:0] result_i,
    input  logic [RES_W-1:0] operand_i,
    output logic [RES_W-1:0] operand_o,
    output logic             hold_o
);
    logic             fwd_q;
    logic [RES_W-1:0] res_q;

    // Forward flag: set by a command, dropped by the consuming issue.
    always_ff @(posedge clk) begin
        if (!rst_n)        fwd_q <= 1'b0;
        else if (cmd_i)    fwd_q <= 1'b1;
        else if (issue_i)  fwd_q <= 1'b0;
    end

    // Result register: loaded on each command.
    always_ff @(posedge clk) begin
        if (!rst_n)     res_q <= '0;
        else if (cmd_i) res_q <= result_i;
    end

    // Operand substitution and interrupt shield.
    always_comb begin
        operand_o = fwd_q ? res_q : operand_i;
        hold_o    = fwd_q;
    end

    AST_FWD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i |=> hold_o);  // R6
    AST_FWD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !cmd_i) |=> !hold_o);  // R6
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i && !issue_i) |=> ($stable(hold_o) && $stable(res_q)));  // R5
    AST_SHIELD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(cmd_i));  // R7
endmodule

// File: rtl/prng_dstep_unit.sv
// Module: top of the double-step random number unit. Chains STEPS steps in one cycle,
// scrambles each step's state into one result word, and forwards the result.
// Assumes: the write-back of state_out to the register is handled by the pipeline.
module prng_dstep_unit #(
    parameter int HALF_W = prng_dstep_pkg::XO_HALF_W,
    parameter int STEPS  = prng_dstep_pkg::XO_STEPS,
    parameter int ROT_A  = prng_dstep_pkg::XO_ROT_A,
    parameter int SHL_B  = prng_dstep_pkg::XO_SHL_B,
    parameter int ROT_C  = prng_dstep_pkg::XO_ROT_C,
    localparam int ST_W  = 2 * HALF_W,
    localparam int RES_W = STEPS * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [ST_W-1:0]  state_in,
    output logic [ST_W-1:0]  state_out,
    input  logic             issue_strobe,
    input  logic [RES_W-1:0] src_operand_in,
    output logic [RES_W-1:0] src_operand_out,
    output logic             irq_hold
);
    logic [ST_W-1:0]  chain [0:STEPS];
    logic [RES_W-1:0] result_d;

    assign chain[0] = state_in;

    // One step plus one scrambler per chained iteration; step g fills word g.
    for (genvar g = 0; g < STEPS; g++) begin : g_iter
        xo_step #(
            .HALF_W(HALF_W), .ROT_A(ROT_A), .SHL_B(SHL_B), .ROT_C(ROT_C)
        ) u_step (
            .state_i(chain[g]),
            .state_o(chain[g+1])
        );
        xo_scramble #(.HALF_W(HALF_W)) u_scr (
            .state_i(chain[g+1]),
            .word_o (result_d[g*HALF_W +: HALF_W])
        );
    end

    assign state_out = chain[STEPS];

    xo_forward #(.RES_W(RES_W)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd_valid),
        .issue_i  (issue_strobe),
        .result_i (result_d),
        .operand_i(src_operand_in),
        .operand_o(src_operand_out),
        .hold_o   (irq_hold)
    );

    AST_ZERO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_in == '0) |-> (state_out == '0));  // R8
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && state_in == '0) |=> (src_operand_out == '0));  // R8
endmodule

// File: tb/test_prng_dstep_unit.sv
`timescale 1ns/100ps
// Bench: chains commands from several seeds against a one-step model.
module test_prng_dstep_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        issue_strobe = 1'b0;
    logic [31:0] state_in = '0;
    logic [31:0] src_operand_in = '0;
    logic [31:0] state_out, src_operand_out;
    logic        irq_hold;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    prng_dstep_unit i_prng_dstep_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .state_in(state_in),
        .state_out(state_out), .issue_strobe(issue_strobe),
        .src_operand_in(src_operand_in), .src_operand_out(src_operand_out),
        .irq_hold(irq_hold)
    );

    function automatic logic [31:0] m_step(input logic [31:0] s);
        logic [15:0] a, b, t, ra, nh, nl;
        a  = s[15:0];
        b  = s[31:16];
        t  = a ^ b;
        ra = {a[1:0], a[15:2]};
        nl = ra ^ {t[13:0], 2'b00} ^ t;
        nh = {t[8:0], t[15:9]};
        return {nh, nl};
    endfunction

    function automatic logic [15:0] m_word(input logic [31:0] s);
        logic [16:0] sm;
        logic        p;
        sm = 17'(s[15:0]) + 17'(s[31:16]);
        p  = 1'b0;
        for (int i = 0; i < 17; i++) p = p ^ sm[i];
        return {sm[15:1], p};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One command on a state; returns model state and result.
    task automatic run_cmd(input logic [31:0] st, output logic [31:0] nxt, output logic [31:0] res);
        logic [31:0] s1, s2;
        s1  = m_step(st);
        s2  = m_step(s1);
        nxt = s2;
        res = {m_word(s2), m_word(s1)};
        @(negedge clk);
        state_in  = st;
        cmd_valid = 1'b1;
        #1;
        check(state_out == s2, "R1 R2 state_out", state_out, s2);
        @(negedge clk);
        cmd_valid = 1'b0;
        src_operand_in = ~st;
        #1;
        check(irq_hold == 1'b1, "R7 irq_hold after command", 32'(irq_hold), 32'd1);
        check(src_operand_out == res, "R3 R4 R5 forwarded result", src_operand_out, res);
        issue_strobe = 1'b1;
        @(negedge clk);
        issue_strobe = 1'b0;
        #1;
        check(irq_hold == 1'b0, "R6 flag cleared by issue", 32'(irq_hold), 32'd0);
        check(src_operand_out == src_operand_in, "R5 passthrough after issue", src_operand_out, src_operand_in);
    endtask

    initial begin
        logic [31:0] st, nx, rs, rs_old;
        logic [31:0] seeds [4];
        seeds[0] = 32'h0000_0001; seeds[1] = 32'h8000_0000;
        seeds[2] = 32'hDEAD_BEEF; seeds[3] = 32'hFFFF_FFFF;
        src_operand_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        check(irq_hold == 1'b0, "R9 irq_hold in reset", 32'(irq_hold), 32'd0);
        check(src_operand_out == 32'h1234_5678, "R9 passthrough in reset", src_operand_out, 32'h1234_5678);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(irq_hold == 1'b0, "R9 irq_hold after reset", 32'(irq_hold), 32'd0);

        // Long chains from several seeds
        for (int k = 0; k < 4; k++) begin
            st = seeds[k];
            for (int n = 0; n < 1000; n++) begin
                run_cmd(st, nx, rs);
                st = nx;
            end
        end

        // R8: zero state
        run_cmd(32'h0, nx, rs);
        check(nx == 32'h0 && rs == 32'h0, "R8 model zero", rs, 32'h0);

        // Same-edge command and issue: old result seen, new one captured
        @(negedge clk);
        state_in = 32'h0BAD_F00D;
        cmd_valid = 1'b1;
        rs_old = {m_word(m_step(m_step(32'h0BAD_F00D))), m_word(m_step(32'h0BAD_F00D))};
        @(negedge clk);
        state_in = 32'h1357_9BDF;
        rs = {m_word(m_step(m_step(32'h1357_9BDF))), m_word(m_step(32'h1357_9BDF))};
        issue_strobe = 1'b1;
        #1;
        check(src_operand_out == rs_old, "R6 old result in tie cycle", src_operand_out, rs_old);
        @(negedge clk);
        cmd_valid = 1'b0;
        issue_strobe = 1'b0;
        #1;
        check(irq_hold == 1'b1, "R6 command wins tie", 32'(irq_hold), 32'd1);
        check(src_operand_out == rs, "R6 new result after tie", src_operand_out, rs);

        // Idle cycles keep the result waiting
        repeat (5) @(negedge clk);
        #1;
        check(src_operand_out == rs, "R5 result held while idle", src_operand_out, rs);

        // R9: reset clears a pending result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(irq_hold == 1'b0, "R9 reset clears flag", 32'(irq_hold), 32'd0);
        check(src_operand_out == src_operand_in, "R9 passthrough after reset", src_operand_out, src_operand_in);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule